// File: doc/BRIEF.md
# Segmented-Page Address Translator

This block maps a 20-bit logical address onto a 20-bit physical address in two registered table lookups. The upper 4 bits of the logical address pick an entry in a small segment table. That entry holds a base pointer into a shared page table and a limit on how many pages the segment owns. The next 8 bits, the page number, are added to the base pointer to select one page table entry. That entry holds a valid bit, a 2-bit access-rights code and a 12-bit block number. The low 8 bits, the word within the page, are not translated. They are appended below the block number.

Every lookup is also checked. A page number at or past the segment limit gives an address error. An invalid page entry gives a page fault. An access that the page's rights code does not allow gives a protection fault. Each faulting lookup raises exactly one of these three flags and returns a zero physical address.

Two write ports load the tables. They run independently of the lookup path, and a write is seen by the translation presented in the following cycle.

Top module: `seg_page_xlat`

## Requirements
- R1: The physical address is the 12-bit block number in bits 19:8 followed by the logical word field (logical bits 7:0) unchanged in bits 7:0. For example, segment 6, page 0x02 and word 0x7E map to 0x0197E when that page's entry holds block 0x019.
- R2: The segment field (logical bits 19:16) selects a segment entry. The page table entry used is the one at index (segment base + page field, logical bits 15:8) modulo the page table depth (1024). The block number comes from that entry.
- R3: A request presented with `in_valid` high in cycle t produces `out_valid` high in cycle t+2 and in no other cycle. The result and the fault flags are held in that same cycle.
- R4: If the page field is greater than or equal to the segment's limit (limit range 0..256), `out_addr_err` is raised and `out_pa` is 0.
- R5: If the selected page entry has its valid bit at 0 and R4 does not apply, `out_page_fault` is raised and `out_pa` is 0.
- R6: Rights code 0 (read/write) allows every access. Rights code 1 (read only) raises `out_prot_fault` for a write (`in_acc`=1) and allows a read (`in_acc`=0) or an execute (`in_acc`=2).
- R7: Rights code 2 (execute only) raises `out_prot_fault` for any access except an execute (`in_acc`=2). Access code 3 is treated as a read.
- R8: Rights code 3 (system only) raises `out_prot_fault` when `in_sup` is 0 and allows every access when `in_sup` is 1.
- R9: At most one fault flag is high at a time. The address error takes priority over the page fault, and the page fault takes priority over the protection fault. A fault flag is raised only together with `out_valid`.
- R10: A segment or page table write in cycle t is used by a translation presented in cycle t+1.
- R11: Synchronous active-high `rst` clears the pipeline. After reset, `out_valid` and all fault flags are 0 until a new request arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Translation request strobe |
| in_lva | input | 20 | Logical address: segment, page, word |
| in_acc | input | 2 | Access type: 0 read, 1 write, 2 execute, 3 read |
| in_sup | input | 1 | 1 = supervisor access, 0 = user access |
| seg_we | input | 1 | Segment table write enable |
| seg_waddr | input | 4 | Segment entry to write |
| seg_wbase | input | 10 | Page table base pointer for that segment |
| seg_wlimit | input | 9 | Number of pages in that segment (0..256) |
| pt_we | input | 1 | Page table write enable |
| pt_waddr | input | 10 | Page table entry to write |
| pt_wvalid | input | 1 | Valid bit of the entry |
| pt_wrights | input | 2 | Rights code of the entry |
| pt_wblock | input | 12 | Block number of the entry |
| out_valid | output | 1 | Result strobe, two cycles after the request |
| out_pa | output | 20 | Physical address, 0 on any fault |
| out_addr_err | output | 1 | Page beyond segment limit |
| out_page_fault | output | 1 | Selected page entry is invalid |
| out_prot_fault | output | 1 | Access not allowed by the rights code |

## Verification
Every segment is loaded with its own base and limit. Limits include zero, full (256) and values in between. The page table is filled with a pattern that mixes valid bits, rights codes and block numbers, so that neighbouring indices differ. Each segment is then probed with the first page, the pages on either side of its limit, the last page and one page in the middle. Each probe is repeated for all three access types in both privilege modes, which separates each rights rule from the others and from the limit and valid checks. Some probes fail more than one check at once, which shows the fault priority. Writes directly followed by a translation show that table updates are visible one cycle later. The worked example address covers the word pass-through.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
  typedef enum logic [1:0] {
    RT_RW  = 2'd0,
    RT_RO  = 2'd1,
    RT_XO  = 2'd2,
    RT_SYS = 2'd3
  } rights_t;

  typedef enum logic [1:0] {
    AC_READ  = 2'd0,
    AC_WRITE = 2'd1,
    AC_EXEC  = 2'd2,
    AC_RSVD  = 2'd3
  } acc_t;
endpackage

// File: rtl/seg_table.sv
module seg_table #(
  parameter int SEG_W = 4,
  parameter int PT_AW = 10,
  parameter int LIM_W = 9
) (
  input  logic             clk,
  input  logic             we,
  input  logic [SEG_W-1:0] waddr,
  input  logic [PT_AW-1:0] wbase,
  input  logic [LIM_W-1:0] wlimit,
  input  logic [SEG_W-1:0] raddr,
  output logic [PT_AW-1:0] rbase,
  output logic [LIM_W-1:0] rlimit
);
  localparam int DEPTH = 1 << SEG_W;
  localparam int ENT_W = PT_AW + LIM_W;

  logic [ENT_W-1:0] mem [DEPTH];
  logic [ENT_W-1:0] rdata;

  // synchronous read, read-first: block RAM friendly
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= {wbase, wlimit};
    rdata <= mem[raddr];
  end

  assign rbase  = rdata[ENT_W-1:LIM_W];
  assign rlimit = rdata[LIM_W-1:0];
endmodule

// File: rtl/page_table.sv
module page_table #(
  parameter int PT_AW = 10,
  parameter int BLK_W = 12
) (
  input  logic             clk,
  input  logic             we,
  input  logic [PT_AW-1:0] waddr,
  input  logic             wvalid,
  input  logic [1:0]       wrights,
  input  logic [BLK_W-1:0] wblock,
  input  logic [PT_AW-1:0] raddr,
  output logic             rvalid,
  output logic [1:0]       rrights,
  output logic [BLK_W-1:0] rblock
);
  localparam int DEPTH = 1 << PT_AW;
  localparam int ENT_W = BLK_W + 3;

  logic [ENT_W-1:0] mem [DEPTH];
  logic [ENT_W-1:0] rdata;

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= {wvalid, wrights, wblock};
    rdata <= mem[raddr];
  end

  assign rvalid  = rdata[ENT_W-1];
  assign rrights = rdata[ENT_W-2:BLK_W];
  assign rblock  = rdata[BLK_W-1:0];
endmodule

// File: rtl/rights_check.sv
module rights_check
  import xlat_pkg::*;
(
  input  rights_t rights,
  input  acc_t    acc,
  input  logic    sup,
  output logic    fault
);
  always_comb begin
    unique case (rights)
      RT_RW:   fault = 1'b0;
      RT_RO:   fault = (acc == AC_WRITE);
      RT_XO:   fault = (acc != AC_EXEC);
      RT_SYS:  fault = !sup;
      default: fault = 1'b0;
    endcase
  end

  // R8
  always_comb begin
    if (rights == RT_SYS && sup == 1'b0)
      sys_user_chk: assert (fault);
  end
endmodule

// File: rtl/seg_page_xlat.sv
module seg_page_xlat
  import xlat_pkg::*;
#(
  parameter int SEG_W  = 4,
  parameter int PAGE_W = 8,
  parameter int WORD_W = 8,
  parameter int BLK_W  = 12,
  parameter int PT_AW  = 10,
  localparam int LA_W  = SEG_W + PAGE_W + WORD_W,
  localparam int PA_W  = BLK_W + WORD_W,
  localparam int LIM_W = PAGE_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [LA_W-1:0]   in_lva,
  input  logic [1:0]        in_acc,
  input  logic              in_sup,
  input  logic              seg_we,
  input  logic [SEG_W-1:0]  seg_waddr,
  input  logic [PT_AW-1:0]  seg_wbase,
  input  logic [LIM_W-1:0]  seg_wlimit,
  input  logic              pt_we,
  input  logic [PT_AW-1:0]  pt_waddr,
  input  logic              pt_wvalid,
  input  logic [1:0]        pt_wrights,
  input  logic [BLK_W-1:0]  pt_wblock,
  output logic              out_valid,
  output logic [PA_W-1:0]   out_pa,
  output logic              out_addr_err,
  output logic              out_page_fault,
  output logic              out_prot_fault
);
  // field split of the logical address
  logic [SEG_W-1:0]  la_seg;
  logic [PAGE_W-1:0] la_page;
  logic [WORD_W-1:0] la_word;
  assign {la_seg, la_page, la_word} = in_lva;

  // stage 1: segment lookup
  logic              s1_vld;
  logic [PAGE_W-1:0] s1_page;
  logic [WORD_W-1:0] s1_word;
  acc_t              s1_acc;
  logic              s1_sup;
  logic [PT_AW-1:0]  s1_base;
  logic [LIM_W-1:0]  s1_limit;

  seg_table #(.SEG_W(SEG_W), .PT_AW(PT_AW), .LIM_W(LIM_W)) u_seg (
    .clk    (clk),
    .we     (seg_we),
    .waddr  (seg_waddr),
    .wbase  (seg_wbase),
    .wlimit (seg_wlimit),
    .raddr  (la_seg),
    .rbase  (s1_base),
    .rlimit (s1_limit)
  );

  always_ff @(posedge clk) begin
    if (rst) s1_vld <= 1'b0;
    else     s1_vld <= in_valid;
    s1_page <= la_page;
    s1_word <= la_word;
    s1_acc  <= acc_t'(in_acc);
    s1_sup  <= in_sup;
  end

  // stage 2: page lookup, index = base + page (wraps at table depth)
  logic [PT_AW-1:0] pt_idx;
  assign pt_idx = s1_base + PT_AW'(s1_page);

  logic              s2_vld;
  logic              s2_lim_err;
  logic [WORD_W-1:0] s2_word;
  acc_t              s2_acc;
  logic              s2_sup;
  logic              pt_rvalid;
  logic [1:0]        pt_rrights;
  logic [BLK_W-1:0]  pt_rblock;

  page_table #(.PT_AW(PT_AW), .BLK_W(BLK_W)) u_pt (
    .clk     (clk),
    .we      (pt_we),
    .waddr   (pt_waddr),
    .wvalid  (pt_wvalid),
    .wrights (pt_wrights),
    .wblock  (pt_wblock),
    .raddr   (pt_idx),
    .rvalid  (pt_rvalid),
    .rrights (pt_rrights),
    .rblock  (pt_rblock)
  );

  always_ff @(posedge clk) begin
    if (rst) s2_vld <= 1'b0;
    else     s2_vld <= s1_vld;
    s2_lim_err <= ({1'b0, s1_page} >= s1_limit);
    s2_word    <= s1_word;
    s2_acc     <= s1_acc;
    s2_sup     <= s1_sup;
  end

  // protection decode on the registered page entry
  logic rc_fault;
  rights_check u_rc (
    .rights (rights_t'(pt_rrights)),
    .acc    (s2_acc),
    .sup    (s2_sup),
    .fault  (rc_fault)
  );

  logic any_fault;
  assign out_valid      = s2_vld;
  assign out_addr_err   = s2_vld && s2_lim_err;
  assign out_page_fault = s2_vld && !s2_lim_err && !pt_rvalid;
  assign out_prot_fault = s2_vld && !s2_lim_err && pt_rvalid && rc_fault;
  assign any_fault      = out_addr_err || out_page_fault || out_prot_fault;
  assign out_pa         = (s2_vld && !any_fault) ? {pt_rblock, s2_word} : '0;

  // R3
  latency_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |-> ##2 out_valid);

  // R9
  one_fault_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({out_addr_err, out_page_fault, out_prot_fault}));

  // R9
  fault_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> !(out_addr_err || out_page_fault || out_prot_fault));

  // R4
  fault_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (out_addr_err || out_page_fault || out_prot_fault) |-> (out_pa == '0));

  // R1
  word_pass_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_pa != '0 && $past(in_valid, 2))
      |-> (out_pa[WORD_W-1:0] == $past(in_lva[WORD_W-1:0], 2)));
endmodule

// File: tb/seg_page_xlat_tb_top.sv
module seg_page_xlat_tb_top;
  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid;
  logic [19:0] in_lva;
  logic [1:0]  in_acc;
  logic        in_sup;
  logic        seg_we;
  logic [3:0]  seg_waddr;
  logic [9:0]  seg_wbase;
  logic [8:0]  seg_wlimit;
  logic        pt_we;
  logic [9:0]  pt_waddr;
  logic        pt_wvalid;
  logic [1:0]  pt_wrights;
  logic [11:0] pt_wblock;
  logic        out_valid;
  logic [19:0] out_pa;
  logic        out_addr_err;
  logic        out_page_fault;
  logic        out_prot_fault;

  seg_page_xlat dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_lva(in_lva),
    .in_acc(in_acc), .in_sup(in_sup),
    .seg_we(seg_we), .seg_waddr(seg_waddr), .seg_wbase(seg_wbase),
    .seg_wlimit(seg_wlimit),
    .pt_we(pt_we), .pt_waddr(pt_waddr), .pt_wvalid(pt_wvalid),
    .pt_wrights(pt_wrights), .pt_wblock(pt_wblock),
    .out_valid(out_valid), .out_pa(out_pa), .out_addr_err(out_addr_err),
    .out_page_fault(out_page_fault), .out_prot_fault(out_prot_fault)
  );

  always #10 clk = ~clk;  // 50 MHz

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  // bench copy of table contents it wrote
  int m_base [16];
  int m_lim  [16];
  int m_val  [1024];
  int m_rt   [1024];
  int m_blk  [1024];

  task automatic check(string tag, logic [23:0] act, logic [23:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr_seg(int s, int base, int lim);
    @(negedge clk);
    pt_we = 0; seg_we = 1;
    seg_waddr = 4'(s); seg_wbase = 10'(base); seg_wlimit = 9'(lim);
    m_base[s] = base; m_lim[s] = lim;
  endtask

  task automatic wr_pt(int i, int v, int r, int b);
    @(negedge clk);
    seg_we = 0; pt_we = 1;
    pt_waddr = 10'(i); pt_wvalid = 1'(v); pt_wrights = 2'(r); pt_wblock = 12'(b);
    m_val[i] = v; m_rt[i] = r; m_blk[i] = b;
  endtask

  // translate and compare {valid, aerr, pf, prot, pa}
  task automatic xlat(int s, int pg, int wd, int acc, int sup, string force_tag);
    int idx, rt;
    bit aerr, pf, pfl, bad;
    logic [23:0] exp;
    string tag;
    idx  = (m_base[s] + pg) % 1024;
    rt   = m_rt[idx];
    aerr = (pg >= m_lim[s]);
    pfl  = (m_val[idx] == 0);
    case (rt)
      0: bad = 0;
      1: bad = (acc == 1);
      2: bad = (acc != 2);
      default: bad = (sup == 0);
    endcase
    pf = !aerr && pfl;
    if (aerr) begin
      exp = {1'b1, 3'b100, 20'h0};
      tag = (pfl || bad) ? "R9" : "R4";
    end else if (pfl) begin
      exp = {1'b1, 3'b010, 20'h0};
      tag = bad ? "R9" : "R5";
    end else if (bad) begin
      exp = {1'b1, 3'b001, 20'h0};
      tag = (rt == 1) ? "R6" : (rt == 2) ? "R7" : "R8";
    end else begin
      exp = {1'b1, 3'b000, 12'(m_blk[idx]), 8'(wd)};
      tag = "R2";
    end
    if (force_tag != "") tag = force_tag;
    @(negedge clk);
    seg_we = 0; pt_we = 0;
    in_valid = 1; in_lva = {4'(s), 8'(pg), 8'(wd)};
    in_acc = 2'(acc); in_sup = 1'(sup);
    @(negedge clk);
    in_valid = 0;
    check("R3", {out_valid, out_addr_err, out_page_fault, out_prot_fault, 20'h0}, 24'h0);
    @(negedge clk);
    check(tag, {out_valid, out_addr_err, out_page_fault, out_prot_fault, out_pa}, exp);
    if (pf) begin end
  endtask

  initial begin
    int pages [6];
    rst = 1; in_valid = 0; in_lva = 0; in_acc = 0; in_sup = 0;
    seg_we = 0; seg_waddr = 0; seg_wbase = 0; seg_wlimit = 0;
    pt_we = 0; pt_waddr = 0; pt_wvalid = 0; pt_wrights = 0; pt_wblock = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R11 reset state
    check("R11", {out_valid, out_addr_err, out_page_fault, out_prot_fault, 20'h0}, 24'h0);

    for (int s = 0; s < 16; s++)
      wr_seg(s, (s * 67) % 1024, (s == 0) ? 0 : (s == 15) ? 256 : 16 * s + 3);
    for (int i = 0; i < 1024; i++)
      wr_pt(i, ((i % 7) != 3) ? 1 : 0, (i / 3) % 4, (i * 37 + 5) % 4096);

    for (int s = 0; s < 16; s++) begin
      pages[0] = 0;
      pages[1] = (m_lim[s] > 0) ? m_lim[s] - 1 : 1;
      pages[2] = (m_lim[s] < 256) ? m_lim[s] : 200;
      pages[3] = 255;
      pages[4] = (s * 13) % 256;
      pages[5] = 1;
      for (int p = 0; p < 6; p++)
        for (int a = 0; a < 3; a++)
          for (int u = 0; u < 2; u++)
            xlat(s, pages[p], (s * 29 + pages[p] + a) % 256, a, u, "");
    end

    // access code 3 acts as a read (R7): execute-only entry faults
    wr_pt(404, 1, 2, 12'h123);
    xlat(6, 2, 8'h11, 3, 0, "R7");

    // worked example: segment 6 page 02 -> block 019 (R1)
    wr_pt((m_base[6] + 2) % 1024, 1, 0, 12'h019);
    xlat(6, 2, 8'h7E, 0, 0, "R1");
    // write immediately followed by a translation (R10)
    wr_pt((m_base[6] + 2) % 1024, 1, 0, 12'h0A6);
    xlat(6, 2, 8'h7E, 1, 0, "R10");
    wr_seg(6, m_base[6], 2);
    xlat(6, 2, 8'h7E, 0, 0, "R10");
    wr_seg(6, m_base[6], 3);
    xlat(6, 2, 8'h7E, 0, 0, "R10");

    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule